// File: doc/BRIEF.md
# Decode Slot Allocator

This block sits between an instruction queue and a row of decoders. Each queue entry arrives already tagged with its uop count, a flag that says it can fuse with a following conditional branch, and a flag that says it is itself a conditional branch. Every cycle the allocator looks at a window of the oldest entries and picks which of them go to the decoder slots. It reports how many entries the queue may drop, and it passes oversized instructions to a microcode sequencer.

Slot 0 is a full decoder and takes an instruction of one to four uops. Every other slot takes only single-uop instructions. The uops placed in one cycle add up to at most four. A fusible compare followed directly by a branch travels as one fused uop. A fusible instruction that would close a cycle with nothing visible behind it is held back, so that a branch arriving a little later can still pair with it.

A configuration input turns on a fifth simple slot and raises the budget to five. The decisions are combinational on the presented window. Only the hold-back marker and the count of remaining microcode uops are stored.

Top module: `dec_alloc_top`

## Requirements
- R1: After reset the microcode sequencer is idle (`mseq_busy` low). With an empty window no slot is valid and `take` is 0.
- R2: Each window entry carries a uop count from 1 to 31 in its `UW`-bit field. Single-uop instructions are placed in order, one per slot. In normal mode up to four are placed per cycle, and `take` reports how many entries were used.
- R3: The uops placed in one cycle add up to at most 4 in normal mode and at most 5 in wide mode. A multi-uop instruction in slot 0 is followed by single-uop instructions only up to that total (2-1-1, 3-1).
- R4: An instruction of 2 to 4 uops is placed only in slot 0. When such an instruction is next in line behind slot 0, the cycle ends before it.
- R5: An instruction of more than 4 uops at the head of the window raises `mseq_start`, shows its count on `mseq_len` and consumes that one entry. No slot is valid in that cycle. If such an instruction is not at the head, the cycle ends before it.
- R6: In each cycle after a start the sequencer delivers min(4, remaining) uops on `mseq_uops` with `mseq_busy` high, until the count is used up. While busy, no slot is valid and `take` is 0.
- R7: A single-uop fusible entry whose next visible entry has the branch flag set is placed as one slot with `slot_fused` set and a uop count of 1. It consumes two entries and counts one uop against the budget.
- R8: A single-uop fusible entry with no visible entry behind it is not placed, and the cycle ends there.
- R9: A fusible entry held back at the head is released alone in the next cycle if there is still nothing behind it. A fusible entry whose visible follower is not a branch is placed alone at once.
- R10: With `xslot_en` high there are five slots and the budget is five (1-1-1-1-1, 4-1, 3-1-1). With it low, slot 4 is never valid.
- R11: Entries are taken strictly in window order. The valid slots are always contiguous from slot 0, and placement stops at the first entry that cannot fill the next free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xslot_en | input | 1 | Enables the fifth simple slot and a budget of five |
| win_vld | input | QW | Entry i of the window is present (bit i; entry 0 is the oldest) |
| win_uops | input | QW*UW | Uop count of entry i in bits [i*UW +: UW] |
| win_fuse | input | QW | Entry i can fuse with a following branch |
| win_jcc | input | QW | Entry i is a conditional branch |
| slot_vld | output | NS | Slot s holds an instruction |
| slot_uops | output | NS*3 | Uops of slot s in bits [s*3 +: 3] |
| slot_fused | output | NS | Slot s holds a fused compare-and-branch pair |
| take | output | clog2(QW+1) | Number of window entries consumed this cycle |
| mseq_start | output | 1 | Hand the head instruction to the microcode sequencer |
| mseq_len | output | UW | Uop count of the handed-over instruction |
| mseq_busy | output | 1 | Sequencer is delivering uops this cycle |
| mseq_uops | output | 3 | Uops delivered by the sequencer this cycle |

## Verification
Slot contents, `take` and `mseq_start` depend only on the presented window and the stored state, so they are due in the same cycle the window is shown. The bench drives the window on the falling edge and samples one time unit later. The hold-back marker and the sequencer count are stored at the rising edge, so a release, a late pairing or a run of `mseq_uops` shows up one cycle after the cycle that caused it. The model advances its own state only after that edge, and it drops entries from its queue by the number it expected in `take`.

// File: rtl/dec_alloc_pkg.sv
package dec_alloc_pkg;

    // Width of a per-slot uop count; holds values up to 7, so budgets up to 6 fit.
    localparam int SLOT_UW = 3;

    typedef struct packed {
        logic                vld;
        logic                fused;
        logic [SLOT_UW-1:0]  uops;
    } slot_t;

endpackage

// File: rtl/dec_alloc_scan.sv
module dec_alloc_scan
    import dec_alloc_pkg::*;
#(
    parameter int QW   = 8,
    parameter int NS   = 5,
    parameter int BASE = 4,
    parameter int UW   = 5,
    localparam int CW  = $clog2(QW + 1),
    localparam int IW  = $clog2(QW)
) (
    input  logic                xslot_en,
    input  logic                wait_q,
    input  logic                mbusy,
    input  logic [QW-1:0]       win_vld,
    input  logic [QW*UW-1:0]    win_uops,
    input  logic [QW-1:0]       win_fuse,
    input  logic [QW-1:0]       win_jcc,
    output slot_t [NS-1:0]      slots,
    output logic [CW-1:0]       take,
    output logic                hold,
    output logic                mstart,
    output logic [UW-1:0]       mlen
);

    logic [UW-1:0] u_arr [QW];

    always_comb begin
        for (int i = 0; i < QW; i++) begin
            u_arr[i] = win_uops[i*UW +: UW];
        end
    end

    // Walk the window in order, filling slots until an entry does not fit.
    always_comb begin
        int            cur;
        int            used;
        int            lim_s;
        int            bud;
        int            u;
        logic          stop;
        logic          nxt_vis;
        logic [IW-1:0] ix;
        logic [IW-1:0] nx;

        cur    = 0;
        used   = 0;
        stop   = 1'b0;
        hold   = 1'b0;
        mstart = 1'b0;
        mlen   = '0;
        slots  = '0;
        ix     = '0;
        nx     = '0;
        u      = 0;
        nxt_vis = 1'b0;
        lim_s  = xslot_en ? NS : NS - 1;
        bud    = xslot_en ? BASE + 1 : BASE;

        for (int s = 0; s < NS; s++) begin
            if (!stop) begin
                ix = IW'(cur);
                if (mbusy || s >= lim_s || cur >= QW || !win_vld[ix]) begin
                    stop = 1'b1;
                end else begin
                    u = int'(u_arr[ix]);
                    nx = IW'(cur + 1);
                    nxt_vis = (cur + 1 < QW) && win_vld[nx];
                    if (u > BASE) begin
                        // oversized: only from the head, handed to the sequencer
                        if (s == 0) begin
                            mstart = 1'b1;
                            mlen   = u_arr[ix];
                            cur    = cur + 1;
                        end
                        stop = 1'b1;
                    end else if (s > 0 && u > 1) begin
                        stop = 1'b1;
                    end else if (used + u > bud) begin
                        stop = 1'b1;
                    end else if (u == 1 && win_fuse[ix]) begin
                        if (nxt_vis && win_jcc[nx]) begin
                            slots[s].vld   = 1'b1;
                            slots[s].fused = 1'b1;
                            slots[s].uops  = SLOT_UW'(1);
                            cur  = cur + 2;
                            used = used + 1;
                        end else if (nxt_vis || (s == 0 && wait_q)) begin
                            slots[s].vld  = 1'b1;
                            slots[s].uops = SLOT_UW'(1);
                            cur  = cur + 1;
                            used = used + 1;
                        end else begin
                            hold = (s == 0);
                            stop = 1'b1;
                        end
                    end else begin
                        slots[s].vld  = 1'b1;
                        slots[s].uops = SLOT_UW'(u);
                        cur  = cur + 1;
                        used = used + u;
                    end
                end
            end
        end
        take = CW'(cur);
    end

endmodule

// File: rtl/dec_alloc_mseq.sv
module dec_alloc_mseq
    import dec_alloc_pkg::*;
#(
    parameter int BASE = 4,
    parameter int UW   = 5
) (
    input  logic [UW-1:0]      rem,
    output logic [SLOT_UW-1:0] give,
    output logic [UW-1:0]      rem_nxt
);

    logic [UW-1:0] give_full;

    always_comb begin
        give_full = (rem > UW'(BASE)) ? UW'(BASE) : rem;
        rem_nxt   = rem - give_full;
        give      = SLOT_UW'(give_full);
    end

endmodule

// File: rtl/dec_alloc_top.sv
module dec_alloc_top
    import dec_alloc_pkg::*;
#(
    parameter int QW   = 8,
    parameter int NS   = 5,
    parameter int BASE = 4,
    parameter int UW   = 5,
    localparam int CW  = $clog2(QW + 1),
    localparam int SW  = SLOT_UW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xslot_en,
    input  logic [QW-1:0]      win_vld,
    input  logic [QW*UW-1:0]   win_uops,
    input  logic [QW-1:0]      win_fuse,
    input  logic [QW-1:0]      win_jcc,
    output logic [NS-1:0]      slot_vld,
    output logic [NS*SW-1:0]   slot_uops,
    output logic [NS-1:0]      slot_fused,
    output logic [CW-1:0]      take,
    output logic               mseq_start,
    output logic [UW-1:0]      mseq_len,
    output logic               mseq_busy,
    output logic [SW-1:0]      mseq_uops
);

    typedef struct packed {
        logic          wait_f;
        logic [UW-1:0] mrem;
    } state_t;

    state_t          st_d, st_q;
    slot_t [NS-1:0]  slots;
    logic            hold;
    logic            mstart;
    logic [UW-1:0]   mlen;
    logic            mbusy;
    logic [SW-1:0]   give;
    logic [UW-1:0]   mrem_nxt;

    assign mbusy = (st_q.mrem != '0);

    dec_alloc_scan #(
        .QW(QW), .NS(NS), .BASE(BASE), .UW(UW)
    ) i_scan (
        .xslot_en (xslot_en),
        .wait_q   (st_q.wait_f),
        .mbusy    (mbusy),
        .win_vld  (win_vld),
        .win_uops (win_uops),
        .win_fuse (win_fuse),
        .win_jcc  (win_jcc),
        .slots    (slots),
        .take     (take),
        .hold     (hold),
        .mstart   (mstart),
        .mlen     (mlen)
    );

    dec_alloc_mseq #(
        .BASE(BASE), .UW(UW)
    ) i_mseq (
        .rem     (st_q.mrem),
        .give    (give),
        .rem_nxt (mrem_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (mbusy) begin
            st_d.mrem   = mrem_nxt;
            st_d.wait_f = 1'b0;
        end else if (mstart) begin
            st_d.mrem   = mlen;
            st_d.wait_f = 1'b0;
        end else begin
            st_d.wait_f = hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_out
        assign slot_vld[s]            = slots[s].vld;
        assign slot_fused[s]          = slots[s].fused;
        assign slot_uops[s*SW +: SW]  = slots[s].uops;
    end

    assign mseq_start = mstart;
    assign mseq_len   = mlen;
    assign mseq_busy  = mbusy;
    assign mseq_uops  = mbusy ? give : '0;

endmodule

// File: rtl/dec_alloc_chk.sv
module dec_alloc_chk #(
    parameter int QW   = 8,
    parameter int NS   = 5,
    parameter int BASE = 4,
    parameter int UW   = 5,
    localparam int CW  = $clog2(QW + 1),
    localparam int SW  = dec_alloc_pkg::SLOT_UW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xslot_en,
    input logic [NS-1:0]    slot_vld,
    input logic [NS*SW-1:0] slot_uops,
    input logic [NS-1:0]    slot_fused,
    input logic [CW-1:0]    take,
    input logic             mseq_start,
    input logic             mseq_busy,
    input logic [SW-1:0]    mseq_uops
);

    int tot;
    int lim;

    always_comb begin
        tot = 0;
        for (int s = 0; s < NS; s++) begin
            if (slot_vld[s]) tot = tot + int'(slot_uops[s*SW +: SW]);
        end
        lim = xslot_en ? BASE + 1 : BASE;
    end

    AST_UOP_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        tot <= lim); // R3

    AST_NARROW_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !xslot_en |-> !slot_vld[NS-1]); // R10

    AST_MSEQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mseq_busy |-> (slot_vld == '0 && take == '0)); // R6

    AST_MSEQ_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        mseq_busy |-> (mseq_uops != '0 && int'(mseq_uops) <= BASE)); // R6

    AST_MSEQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        mseq_start |=> mseq_busy); // R5

    AST_START_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        mseq_start |-> (slot_vld == '0 && take == CW'(1))); // R5

    for (genvar s = 0; s < NS; s++) begin : g_slot
        AST_FUSED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            slot_fused[s] |-> (slot_vld[s] && slot_uops[s*SW +: SW] == SW'(1))); // R7
        if (s > 0) begin : g_tail
            AST_MULTI_HEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                slot_vld[s] |-> slot_uops[s*SW +: SW] == SW'(1)); // R4
            AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
                slot_vld[s] |-> slot_vld[s-1]); // R11
        end
    end

endmodule

bind dec_alloc_top dec_alloc_chk #(
    .QW(QW), .NS(NS), .BASE(BASE), .UW(UW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xslot_en   (xslot_en),
    .slot_vld   (slot_vld),
    .slot_uops  (slot_uops),
    .slot_fused (slot_fused),
    .take       (take),
    .mseq_start (mseq_start),
    .mseq_busy  (mseq_busy),
    .mseq_uops  (mseq_uops)
);

// File: tb/test_dec_alloc_top.sv
`timescale 1ns/1ps
module test_dec_alloc_top;

    localparam int QW = 8;
    localparam int NS = 5;
    localparam int UW = 5;
    localparam int SW = 3;
    localparam int CW = $clog2(QW + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               xslot_en = 1'b0;
    logic [QW-1:0]      win_vld = '0;
    logic [QW*UW-1:0]   win_uops = '0;
    logic [QW-1:0]      win_fuse = '0;
    logic [QW-1:0]      win_jcc = '0;
    logic [NS-1:0]      slot_vld;
    logic [NS*SW-1:0]   slot_uops;
    logic [NS-1:0]      slot_fused;
    logic [CW-1:0]      take;
    logic               mseq_start;
    logic [UW-1:0]      mseq_len;
    logic               mseq_busy;
    logic [SW-1:0]      mseq_uops;

    always #5 clk = ~clk;

    dec_alloc_top #(.QW(QW), .NS(NS), .BASE(4), .UW(UW)) i_dec_alloc_top (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string tag = "R1";

    int qu[$];
    int qf[$];
    int qj[$];
    bit m_wait = 1'b0;
    int m_rem  = 0;

    // expected values for the current cycle
    logic [NS-1:0]    xv;
    logic [NS*SW-1:0] xu;
    logic [NS-1:0]    xf;
    int               xtake;
    bit               xms;
    int               xml;
    bit               xbusy;
    int               xmu;
    bit               xhold;

    task automatic push(input int u, input int f, input int j);
        qu.push_back(u); qf.push_back(f); qj.push_back(j);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Behavioural reference: what each cycle should produce from the queue.
    task automatic model;
        int n, i, k, tot, bud, slots;
        n = qu.size();
        if (n > QW) n = QW;
        xv = '0; xu = '0; xf = '0; xtake = 0; xms = 0; xml = 0;
        xbusy = 0; xmu = 0; xhold = 0;
        if (m_rem > 0) begin
            xbusy = 1;
            xmu = (m_rem > 4) ? 4 : m_rem;
            return;
        end
        slots = xslot_en ? 5 : 4;
        bud   = xslot_en ? 5 : 4;
        i = 0; k = 0; tot = 0;
        while (k < slots && i < n) begin
            int u;
            u = qu[i];
            if (u > 4) begin
                if (k == 0) begin xms = 1; xml = u; i = i + 1; end
                break;
            end
            if (k > 0 && u > 1) break;
            if (tot + u > bud) break;
            if (u == 1 && qf[i] != 0) begin
                if (i + 1 < n && qj[i+1] != 0) begin
                    xf[k] = 1'b1; xv[k] = 1'b1; xu[k*SW +: SW] = 3'd1;
                    i = i + 2; tot = tot + 1; k = k + 1;
                    continue;
                end
                if (!(i + 1 < n) && !(k == 0 && m_wait)) begin
                    xhold = (k == 0);
                    break;
                end
            end
            xv[k] = 1'b1; xu[k*SW +: SW] = SW'(u);
            i = i + 1; tot = tot + u; k = k + 1;
        end
        xtake = i;
    endtask

    task automatic drive;
        int n;
        n = qu.size();
        win_vld = '0; win_uops = '0; win_fuse = '0; win_jcc = '0;
        for (int i = 0; i < QW; i++) begin
            if (i < n) begin
                win_vld[i] = 1'b1;
                win_uops[i*UW +: UW] = UW'(qu[i]);
                win_fuse[i] = (qf[i] != 0);
                win_jcc[i]  = (qj[i] != 0);
            end
        end
    endtask

    task automatic step;
        @(negedge clk);
        drive();
        model();
        #1;
        checks++;
        if (slot_vld !== xv || slot_uops !== xu || slot_fused !== xf ||
            int'(take) != xtake || mseq_start !== xms || int'(mseq_len) != xml ||
            mseq_busy !== xbusy || int'(mseq_uops) != xmu) begin
            fails++;
            $display("FAIL %s t=%0t: got vld=%b uops=%h fus=%b take=%0d ms=%0d ml=%0d busy=%0d mu=%0d exp vld=%b uops=%h fus=%b take=%0d ms=%0d ml=%0d busy=%0d mu=%0d",
                     tag, $time, slot_vld, slot_uops, slot_fused, take, mseq_start, mseq_len,
                     mseq_busy, mseq_uops, xv, xu, xf, xtake, xms, xml, xbusy, xmu);
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < xtake; i++) begin
            void'(qu.pop_front()); void'(qf.pop_front()); void'(qj.pop_front());
        end
        if (xbusy) begin
            m_rem = m_rem - xmu; m_wait = 0;
        end else if (xms) begin
            m_rem = xml; m_wait = 0;
        end else begin
            m_wait = xhold;
        end
    endtask

    task automatic run(input string t, input int n);
        tag = t;
        for (int c = 0; c < n; c++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no end, exp end of test");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (mseq_busy !== 1'b0 || slot_vld !== '0 || take !== '0) begin
            fails++;
            $display("FAIL R1 reset: got busy=%0d vld=%b take=%0d exp 0 0 0", mseq_busy, slot_vld, take);
        end
        run("R1", 2);

        // R2: plain singles, four per cycle
        for (int i = 0; i < 10; i++) push(1, 0, 0);
        run("R2", 4);

        // R3: 2-1-1 then leftovers; 3-1
        push(2, 0, 0); push(1, 0, 0); push(1, 0, 0); push(1, 0, 0); push(1, 0, 0);
        push(3, 0, 0); push(1, 0, 0); push(1, 0, 0);
        run("R3", 5);

        // R4: multi-uop behind slot 0 stops the cycle
        push(1, 0, 0); push(3, 0, 0); push(4, 0, 0); push(2, 0, 0); push(1, 0, 0);
        run("R4", 5);

        // R5 / R6: oversized instructions go to the sequencer
        push(1, 0, 0); push(7, 0, 0); push(1, 0, 0);
        run("R5", 2);
        run("R6", 4);
        push(9, 0, 0); push(1, 0, 0); push(1, 0, 0);
        run("R6", 6);

        // R7: fused compare-and-branch pairs
        push(1, 1, 0); push(1, 0, 1); push(1, 0, 0); push(1, 1, 0); push(1, 0, 1);
        run("R7", 3);

        // R8: fusible at window end withheld; R9: released alone next cycle
        push(1, 0, 0); push(1, 0, 0); push(1, 1, 0);
        run("R8", 1);
        run("R9", 3);
        // late branch pairs with held fusible
        push(1, 1, 0);
        run("R8", 1);
        push(1, 0, 1);
        run("R7", 2);
        // fusible followed by a non-branch goes at once
        push(1, 1, 0); push(2, 0, 0);
        run("R9", 3);

        // R10: wide mode
        xslot_en = 1'b1;
        for (int i = 0; i < 6; i++) push(1, 0, 0);
        push(4, 0, 0); push(1, 0, 0); push(1, 0, 0);
        push(3, 0, 0); push(1, 0, 0); push(1, 0, 0); push(1, 0, 0);
        run("R10", 6);
        xslot_en = 1'b0;
        for (int i = 0; i < 6; i++) push(1, 0, 0);
        run("R10", 3);

        // R11: mixed traffic in order
        for (int c = 0; c < 400; c++) begin
            int r;
            r = $urandom_range(0, 3);
            for (int p = 0; p < r; p++) begin
                if (qu.size() < 12) begin
                    int k, u;
                    k = $urandom_range(0, 15);
                    u = (k < 9) ? 1 : (k < 13) ? $urandom_range(2, 4) : $urandom_range(5, 12);
                    push(u, (u == 1 && $urandom_range(0, 3) == 0) ? 1 : 0,
                         (u == 1 && $urandom_range(0, 2) == 0) ? 1 : 0);
                end
            end
            if ($urandom_range(0, 19) == 0) xslot_en = ~xslot_en;
            run("R11", 1);
        end
        xslot_en = 1'b0;
        run("R11", 20);
        report();
    end

endmodule